// File: doc/BRIEF.md
# Remote-Armed Intrusion Alarm Controller

This block is a synchronous Moore machine that guards an enclosure. It has a single siren output and takes two single-bit inputs: a remote-control command and an intrusion sensor. A press of the remote while the system is disarmed arms it, and the siren gives one short chirp as confirmation. While the system is armed, a sensor trip latches a continuous alarm. A remote press while armed or during an alarm disarms the system, and the siren gives two chirps separated by a pause as confirmation. Chirp length and pause length are parameters counted in clock cycles. One down-counter times both, and it is reloaded on every state change.

A remote command may be held for many cycles. Each remote-triggered transition is therefore followed by a wait state that holds until the command is released. A long press causes exactly one arm or disarm action and never loops through the states. When the remote and the sensor are both asserted in the armed state, the remote wins. A build option blocks arming while the sensor is active. Both inputs are assumed to be debounced and already synchronous to `clk`.

Top module: `alarm_chirp_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the machine in the disarmed state with `siren` low from that edge on, including when `rst` arrives during an alarm.
- R2: In the disarmed state, `remote_cmd`=1 (with the condition of R8) turns `siren` on from the next edge for exactly `CHIRP_ON` cycles, after which it is low.
- R3: After the arming chirp, a `remote_cmd` that is still held keeps `siren` low and the machine pending. The armed state is entered only after release, so a long press yields exactly one chirp and no disarm.
- R4: In the armed state, `sensor_trip`=1 with `remote_cmd`=0 turns `siren` on from the next edge. `siren` stays on while `remote_cmd` stays low, even after `sensor_trip` returns to 0.
- R5: In the armed state, `remote_cmd`=1 and `sensor_trip`=1 in the same cycle are resolved in favour of the remote. No alarm follows, and the disarm sequence of R6 runs.
- R6: After a disarm press, `siren` is low until `remote_cmd` is released. From the edge that samples the release, `siren` is high for `CHIRP_ON` cycles, low for `CHIRP_OFF` cycles, high for `CHIRP_ON` cycles, and then low in the disarmed state.
- R7: During an alarm, `remote_cmd`=1 turns `siren` off from the next edge, and the disarm sequence of R6 follows the release.
- R8: With `ARM_NEEDS_CLEAR`=1, a remote press in the disarmed state while `sensor_trip`=1 is ignored and `siren` stays low. With `ARM_NEEDS_CLEAR`=0 the same press arms the system.
- R9: Both inputs are ignored during the chirp and pause states of the disarm sequence, so the siren pattern of R6 is unchanged by activity on them.
- R10: In the disarmed state, `sensor_trip` alone has no effect and `siren` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| remote_cmd | input | 1 | Debounced remote-control command, high while pressed |
| sensor_trip | input | 1 | Debounced intrusion sensor, high when tripped |
| siren | output | 1 | Siren enable, high during alarm and chirps |

## Verification
The bench sweeps the length of the arming press from shorter than a chirp to well past it. This shows that the chirp length does not depend on how long the press lasts, and that a held press never turns into a disarm. The disarm is tried from both the armed and the alarm state with press lengths of one to three cycles. In the armed case, the sensor is sometimes asserted together with the remote, which separates the remote-priority path from an alarm. Noise on both inputs during the double chirp shows that the pattern is fixed once it has started. Two instances that differ only in the arming option receive the same press while the sensor is active, and the bench checks that one arms and the other ignores the press.

// File: rtl/alarm_chirp_pkg.sv
package alarm_chirp_pkg;

    typedef enum logic [3:0] {
        ST_DISARMED    = 4'd0,
        ST_ARM_CHIRP   = 4'd1,
        ST_ARM_HOLD    = 4'd2,
        ST_ARMED       = 4'd3,
        ST_ALARM       = 4'd4,
        ST_DIS_HOLD    = 4'd5,
        ST_DIS_CHIRP_A = 4'd6,
        ST_DIS_GAP     = 4'd7,
        ST_DIS_CHIRP_B = 4'd8
    } alm_state_e;

    typedef struct packed {
        logic remote;
        logic sensor;
    } alm_in_s;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Number of cycles a state lasts when it is timed; untimed states report 1.
    function automatic int unsigned dwell_cycles(input alm_state_e s,
                                                 input int unsigned on_len,
                                                 input int unsigned off_len);
        case (s)
            ST_ARM_CHIRP, ST_DIS_CHIRP_A, ST_DIS_CHIRP_B: return on_len;
            ST_DIS_GAP:                                   return off_len;
            default:                                      return 1;
        endcase
    endfunction

    function automatic logic is_sounding(input alm_state_e s);
        return (s == ST_ARM_CHIRP) || (s == ST_DIS_CHIRP_A) ||
               (s == ST_DIS_CHIRP_B) || (s == ST_ALARM);
    endfunction

endpackage

// File: rtl/alm_interval_timer.sv
module alm_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R6: once a dwell has run out the counter rests at zero until reloaded
    timer_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/alm_seq_fsm.sv
module alm_seq_fsm
    import alarm_chirp_pkg::*;
#(
    parameter int unsigned CHIRP_ON        = 4,
    parameter int unsigned CHIRP_OFF       = 4,
    parameter bit          ARM_NEEDS_CLEAR = 1'b0,
    parameter int unsigned CNT_W           = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  alm_in_s          in_i,
    input  logic             expired,
    output alm_state_e       state_o,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    alm_state_e state_q, state_d;
    logic       arm_ok;

    assign arm_ok = in_i.remote && (!ARM_NEEDS_CLEAR || !in_i.sensor);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED:    if (arm_ok)          state_d = ST_ARM_CHIRP;
            ST_ARM_CHIRP:   if (expired)         state_d = ST_ARM_HOLD;
            ST_ARM_HOLD:    if (!in_i.remote)    state_d = ST_ARMED;
            ST_ARMED: begin
                if (in_i.remote)                 state_d = ST_DIS_HOLD;
                else if (in_i.sensor)            state_d = ST_ALARM;
            end
            ST_ALARM:       if (in_i.remote)     state_d = ST_DIS_HOLD;
            ST_DIS_HOLD:    if (!in_i.remote)    state_d = ST_DIS_CHIRP_A;
            ST_DIS_CHIRP_A: if (expired)         state_d = ST_DIS_GAP;
            ST_DIS_GAP:     if (expired)         state_d = ST_DIS_CHIRP_B;
            ST_DIS_CHIRP_B: if (expired)         state_d = ST_DISARMED;
            default:                             state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DISARMED;
        else     state_q <= state_d;
    end

    assign load     = (state_d != state_q);
    assign load_val = CNT_W'(dwell_cycles(state_d, CHIRP_ON, CHIRP_OFF) - 1);
    assign state_o  = state_q;

    // R1
    reset_home_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_DISARMED));
    // R3
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM_HOLD && in_i.remote) |=> (state_q == ST_ARM_HOLD));
    // R4
    alarm_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && in_i.sensor && !in_i.remote) |=> (state_q == ST_ALARM));
    // R4
    alarm_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALARM && !in_i.remote) |=> (state_q == ST_ALARM));
    // R5
    remote_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && in_i.remote) |=> (state_q == ST_DIS_HOLD));
    // R7
    alarm_silence_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALARM && in_i.remote) |=> (state_q == ST_DIS_HOLD));
    // R10
    idle_sensor_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DISARMED && !in_i.remote) |=> (state_q == ST_DISARMED));

    if (ARM_NEEDS_CLEAR) begin : g_clear_gate
        // R8
        sensor_blocks_arm_chk: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_DISARMED && in_i.sensor) |=> (state_q == ST_DISARMED));
    end

endmodule

// File: rtl/alm_siren_dec.sv
module alm_siren_dec
    import alarm_chirp_pkg::*;
(
    input  alm_state_e state_i,
    output logic       siren
);
    assign siren = is_sounding(state_i);
endmodule

// File: rtl/alarm_chirp_ctrl.sv
module alarm_chirp_ctrl
    import alarm_chirp_pkg::*;
#(
    parameter int unsigned CHIRP_ON        = 25_000_000,
    parameter int unsigned CHIRP_OFF       = 25_000_000,
    parameter bit          ARM_NEEDS_CLEAR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic remote_cmd,
    input  logic sensor_trip,
    output logic siren
);
    localparam int unsigned CNT_W = $clog2(max2(CHIRP_ON, CHIRP_OFF) + 1);

    alm_in_s          in_s;
    alm_state_e       state;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    assign in_s.remote = remote_cmd;
    assign in_s.sensor = sensor_trip;

    alm_seq_fsm #(
        .CHIRP_ON        (CHIRP_ON),
        .CHIRP_OFF       (CHIRP_OFF),
        .ARM_NEEDS_CLEAR (ARM_NEEDS_CLEAR),
        .CNT_W           (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_i     (in_s),
        .expired  (expired),
        .state_o  (state),
        .load     (load),
        .load_val (load_val)
    );

    alm_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    alm_siren_dec u_dec (
        .state_i (state),
        .siren   (siren)
    );

    // R2
    chirp_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISARMED && remote_cmd && !sensor_trip) |=> siren);

endmodule

// File: tb/alarm_chirp_ctrl_tb.sv
module alarm_chirp_ctrl_tb;
    localparam int ON  = 3;
    localparam int OFF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic remote = 1'b0;
    logic sensor = 1'b0;
    logic sir_a, sir_b;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    alarm_chirp_ctrl #(.CHIRP_ON(ON), .CHIRP_OFF(OFF), .ARM_NEEDS_CLEAR(1'b0)) u_dut (
        .clk(clk), .rst(rst), .remote_cmd(remote), .sensor_trip(sensor), .siren(sir_a));

    alarm_chirp_ctrl #(.CHIRP_ON(ON), .CHIRP_OFF(OFF), .ARM_NEEDS_CLEAR(1'b1)) u_dut_clr (
        .clk(clk), .rst(rst), .remote_cmd(remote), .sensor_trip(sensor), .siren(sir_b));

    task automatic cyc(input logic r, input logic s);
        remote = r;
        sensor = s;
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: siren=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic exp, input string tag);
        cyc(r, s);
        chk(sir_a, exp, tag);
        chk(sir_b, exp, tag);
    endtask

    // Arming press held for h cycles; ends in the armed state.
    task automatic arm(input int h);
        int last;
        last = ((h > ON + 1) ? h : ON + 1) + 2;
        for (int t = 0; t < last; t++)
            step(t < h, 1'b0, t < ON, (t < ON) ? "R2" : "R3");
    endtask

    task automatic raise_alarm();
        for (int t = 0; t < 3; t++) step(1'b0, 1'b1, 1'b1, "R4");
        for (int t = 0; t < 6; t++) step(1'b0, 1'b0, 1'b1, "R4");
    endtask

    // Disarm press of k cycles, then release with input noise during the pattern.
    task automatic disarm(input int k, input logic with_sen, input string tag);
        int total;
        for (int t = 0; t < k; t++) step(1'b1, with_sen, 1'b0, tag);
        total = 2 * ON + OFF + 3;
        for (int t = 0; t < total; t++) begin
            logic r, s, e;
            r = (t >= 1 && t < ON + OFF) ? t[0] : 1'b0;
            s = (t < ON + OFF);
            e = (t < ON) || (t >= ON + OFF && t < 2 * ON + OFF);
            step(r, s, e, (t >= 1 && t < ON + OFF) ? "R9" : "R6");
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run still active, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(1'b0, 1'b0);
        rst = 1'b0;
        chk(sir_a, 1'b0, "R1");
        chk(sir_b, 1'b0, "R1");

        // R10: sensor alone while disarmed
        for (int t = 0; t < 5; t++) step(1'b0, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, "R10");

        for (int h = 1; h <= 6; h++) begin
            arm(h);
            if (h % 2 == 1) begin
                raise_alarm();
                disarm(h % 3 + 1, 1'b0, "R7");
            end else begin
                disarm(h % 3 + 1, h[1], h[1] ? "R5" : "R6");
            end
        end

        // R1: synchronous reset during an alarm
        arm(1);
        raise_alarm();
        rst = 1'b1;
        cyc(1'b0, 1'b0);
        chk(sir_a, 1'b0, "R1");
        chk(sir_b, 1'b0, "R1");
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");

        // R8: press with sensor active; only the gated instance ignores it
        for (int t = 0; t < ON; t++) begin
            cyc(t == 0, 1'b1);
            chk(sir_a, 1'b1, "R8");
            chk(sir_b, 1'b0, "R8");
        end
        cyc(1'b1, 1'b0);
        chk(sir_b, 1'b1, "R8");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule